// File: doc/BRIEF.md
# Pin Interrupt Trigger Detector

This block turns the debounced level of a group of input pins into interrupt and wake requests. Each pin has its own detection unit. A level-or-edge select and a 2-bit polarity code decide which input behaviour counts as an event. The unit keeps a sticky interrupt status bit and a wake status bit. Software clears both by writing the pin's register with the status bit set, and this block receives that write as a one-cycle clear strobe. No other acknowledge exists.

Event detection is controlled by the pin's enable bit. Delivery of the request is controlled by a separate unmask bit. A pin asks for service when its interrupt status is set and the pin is both enabled and unmasked, or when its wake status is set. Wake status is recorded only while the chip reports one of the low-power states and the pin has wake enabled for that state. The block does not sequence power states. It only reads the state code. All per-pin service requests are ORed into a single summary request.

Top module: `pin_trigger_unit`

## Requirements
- R1: While reset is held and right after it is released, every interrupt status, wake status, per-pin request and the summary request read 0.
- R2: In edge mode (`lvl_mode`=0) with polarity code 01, a pin that was sampled low and is then sampled high sets its interrupt status at that same clock edge.
- R3: In edge mode with polarity code 00, a high-to-low transition sets the interrupt status.
- R4: In edge mode with polarity code 10, a transition in either direction sets the interrupt status.
- R5: Polarity code 11 never sets status in either mode. In level mode, code 10 also never sets status.
- R6: In level mode (`lvl_mode`=1), code 00 sets status on every cycle the pin is low and code 01 on every cycle it is high. A clear strobe given while the level is still active leaves the status set.
- R7: A clear strobe resets both the interrupt and the wake status of its pin, unless a new event is detected on that pin in the same cycle. In that case the status stays set.
- R8: With `irq_en`=0 no status is set. The previous-level sample keeps following the pin, so re-enabling the pin while its level is steady produces no event.
- R9: `pin_req[i]` equals (interrupt status AND `irq_en` AND `irq_unmask`) OR wake status. `sum_req` is the OR of all `pin_req` bits.
- R10: Wake status is set on an enabled event only when `pwr_state` is k in 1..3 and `wake_en[i*3 + k-1]` is 1. `pwr_state`=0 means running, and in that state wake status is never set.
- R11: The first clock edge after reset release cannot detect an edge, whatever the pin level is.
- R12: Without an event or a clear strobe, both status bits hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_level | input | NUM_PINS | Debounced input level per pin |
| irq_en | input | NUM_PINS | Detection enable per pin |
| irq_unmask | input | NUM_PINS | Request delivery enable per pin (1 = unmasked) |
| lvl_mode | input | NUM_PINS | 1 = level trigger, 0 = edge trigger |
| act_sel | input | 2*NUM_PINS | Polarity code per pin: 00 low/falling, 01 high/rising, 10 both edges, 11 none |
| wake_en | input | NUM_PINS*WAKE_STATES | Wake enable per pin and low-power state |
| pwr_state | input | PWR_W | 0 = running, k = low-power state k |
| sts_clr | input | NUM_PINS | Write-one-to-clear strobe for the pin's status |
| irq_sts | output | NUM_PINS | Sticky interrupt status |
| wake_sts | output | NUM_PINS | Sticky wake status |
| pin_req | output | NUM_PINS | Per-pin service request |
| sum_req | output | 1 | OR of all service requests |

## Verification
The assertions assume `pin_level` has already been debounced and synchronised to `clk`. They also assume every configuration input and the clear strobe change only between clock edges and stay stable across each edge. The bench meets this by driving all inputs on the falling edge. It runs directed sequences for each polarity code and mode, then a long stretch of random pins, configuration and power states. At every falling edge it compares all outputs against a behavioural model that keeps its own previous-level and status arrays.

// File: rtl/ptu_pkg.sv
package ptu_pkg;

   typedef enum logic [1:0] {
      POL_LOW_FALL  = 2'b00,
      POL_HIGH_RISE = 2'b01,
      POL_BOTH_EDGE = 2'b10,
      POL_NONE      = 2'b11
   } pol_code_e;

   // Event decode for one pin: level or edge, with polarity code.
   function automatic logic pol_event(input logic      level_mode,
                                      input pol_code_e code,
                                      input logic      cur,
                                      input logic      prv,
                                      input logic      prv_valid);
      logic rise;
      logic fall;
      rise = prv_valid & cur & ~prv;
      fall = prv_valid & ~cur & prv;
      if (level_mode) begin
         case (code)
            POL_LOW_FALL:  return ~cur;
            POL_HIGH_RISE: return cur;
            default:       return 1'b0;
         endcase
      end
      case (code)
         POL_LOW_FALL:  return fall;
         POL_HIGH_RISE: return rise;
         POL_BOTH_EDGE: return rise | fall;
         default:       return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/ptu_event_det.sv
module ptu_event_det
   import ptu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   input  logic       level_mode,
   input  logic [1:0] code,
   output logic       evt
);

   logic prv_q;
   logic prv_valid_q;

   // Previous-level sample always follows the pin, independent of enable.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prv_q       <= 1'b0;
         prv_valid_q <= 1'b0;
      end else begin
         prv_q       <= pin;
         prv_valid_q <= 1'b1;
      end
   end

   always_comb evt = pol_event(level_mode, pol_code_e'(code), pin, prv_q, prv_valid_q);

   // No event is reported for a reserved code in any mode.
   assert_rsvd_code_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 2'b11) |-> !evt);

   // An edge-mode event always follows a stable previous sample.
   assert_edge_needs_history_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !level_mode) |-> prv_valid_q);

endmodule

// File: rtl/ptu_status.sv
module ptu_status (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic en,
   input  logic clr,
   input  logic wake_ok,
   output logic irq_sts,
   output logic wake_sts
);

   logic hit;

   always_comb hit = evt & en;

   // Set has priority over the write-one-to-clear strobe.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_sts  <= 1'b0;
         wake_sts <= 1'b0;
      end else begin
         if (hit)      irq_sts <= 1'b1;
         else if (clr) irq_sts <= 1'b0;

         if (hit && wake_ok) wake_sts <= 1'b1;
         else if (clr)       wake_sts <= 1'b0;
      end
   end

   assert_set_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_sts) |-> $past(en));

   assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !evt) |=> (!irq_sts && !wake_sts));

   assert_event_wins_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && evt && en) |=> irq_sts);

   assert_sticky_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_sts && !clr) |=> irq_sts);

   assert_wake_needs_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_sts) |-> $past(wake_ok && evt));

endmodule

// File: rtl/pin_trigger_unit.sv
module pin_trigger_unit #(
   parameter int NUM_PINS    = 4,
   parameter int WAKE_STATES = 3,
   localparam int WS_W       = (WAKE_STATES > 0) ? WAKE_STATES : 1,
   localparam int PWR_W      = (WAKE_STATES > 0) ? $clog2(WAKE_STATES + 1) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_PINS-1:0]      pin_level,
   input  logic [NUM_PINS-1:0]      irq_en,
   input  logic [NUM_PINS-1:0]      irq_unmask,
   input  logic [NUM_PINS-1:0]      lvl_mode,
   input  logic [2*NUM_PINS-1:0]    act_sel,
   input  logic [NUM_PINS*WS_W-1:0] wake_en,
   input  logic [PWR_W-1:0]         pwr_state,
   input  logic [NUM_PINS-1:0]      sts_clr,
   output logic [NUM_PINS-1:0]      irq_sts,
   output logic [NUM_PINS-1:0]      wake_sts,
   output logic [NUM_PINS-1:0]      pin_req,
   output logic                     sum_req
);

   // Elaboration-time parameter checks.
   if (NUM_PINS < 1 || NUM_PINS > 64) begin : g_bad_pins
      $error("pin_trigger_unit: NUM_PINS out of range");
   end
   if (WAKE_STATES < 0 || WAKE_STATES > 7) begin : g_bad_wake
      $error("pin_trigger_unit: WAKE_STATES out of range");
   end

   logic [WS_W-1:0] state_hot;

   if (WAKE_STATES > 0) begin : g_state_dec
      for (genvar s = 0; s < WAKE_STATES; s++) begin : g_st
         always_comb state_hot[s] = (pwr_state == PWR_W'(s + 1));
      end
   end else begin : g_no_state
      always_comb state_hot = '0;
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic evt;
      logic wake_ok;

      ptu_event_det u_det (
         .clk        (clk),
         .rst_n      (rst_n),
         .pin        (pin_level[i]),
         .level_mode (lvl_mode[i]),
         .code       (act_sel[2*i +: 2]),
         .evt        (evt)
      );

      if (WAKE_STATES > 0) begin : g_wake
         always_comb wake_ok = |(wake_en[i*WS_W +: WS_W] & state_hot);
      end else begin : g_nowake
         always_comb wake_ok = 1'b0;
      end

      ptu_status u_sts (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt      (evt),
         .en       (irq_en[i]),
         .clr      (sts_clr[i]),
         .wake_ok  (wake_ok),
         .irq_sts  (irq_sts[i]),
         .wake_sts (wake_sts[i])
      );

      always_comb pin_req[i] = (irq_sts[i] & irq_en[i] & irq_unmask[i]) | wake_sts[i];
   end

   always_comb sum_req = |pin_req;

   assert_masked_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_sts == '0 && (irq_sts & irq_en & irq_unmask) == '0) |-> !sum_req);

   assert_running_no_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pwr_state) == '0) |-> (($past(wake_sts) | ~wake_sts) == '1));

endmodule

// File: tb/test_pin_trigger_unit.sv
module test_pin_trigger_unit;
   localparam int N  = 4;
   localparam int WS = 3;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n;
   logic [N-1:0]  pin_level, irq_en, irq_unmask, lvl_mode, sts_clr;
   logic [2*N-1:0] act_sel;
   logic [N*WS-1:0] wake_en;
   logic [1:0]    pwr_state;
   logic [N-1:0]  irq_sts, wake_sts, pin_req;
   logic          sum_req;

   pin_trigger_unit #(.NUM_PINS(N), .WAKE_STATES(WS)) i_pin_trigger_unit (
      .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .irq_en(irq_en),
      .irq_unmask(irq_unmask), .lvl_mode(lvl_mode), .act_sel(act_sel),
      .wake_en(wake_en), .pwr_state(pwr_state), .sts_clr(sts_clr),
      .irq_sts(irq_sts), .wake_sts(wake_sts), .pin_req(pin_req), .sum_req(sum_req)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // Behavioural model state
   bit m_prev[N];
   bit m_sts[N];
   bit m_wake[N];
   bit m_primed;

   function automatic bit model_evt(int i);
      int code = int'(act_sel[2*i +: 2]);
      bit p = pin_level[i];
      if (lvl_mode[i]) begin
         if (code == 0) return !p;
         if (code == 1) return p;
         return 0;
      end
      if (!m_primed) return 0;
      if (code == 0) return (m_prev[i] && !p);
      if (code == 1) return (!m_prev[i] && p);
      if (code == 2) return (m_prev[i] != p);
      return 0;
   endfunction

   task automatic advance();
      for (int i = 0; i < N; i++) begin
         bit e = model_evt(i) && irq_en[i];
         bit w = (pwr_state != 0) && wake_en[i*WS + int'(pwr_state) - 1];
         if (e) m_sts[i] = 1; else if (sts_clr[i]) m_sts[i] = 0;
         if (e && w) m_wake[i] = 1; else if (sts_clr[i]) m_wake[i] = 0;
         m_prev[i] = pin_level[i];
      end
      m_primed = 1;
   endtask

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare(string tag);
      bit any = 0;
      for (int i = 0; i < N; i++) begin
         bit r = (m_sts[i] && irq_en[i] && irq_unmask[i]) || m_wake[i];
         any |= r;
         chk(tag, $sformatf("irq_sts[%0d]", i), int'(irq_sts[i]), int'(m_sts[i]));
         chk(tag, $sformatf("wake_sts[%0d]", i), int'(wake_sts[i]), int'(m_wake[i]));
         chk(tag, $sformatf("pin_req[%0d]", i), int'(pin_req[i]), int'(r));
      end
      chk(tag, "sum_req", int'(sum_req), int'(any));
   endtask

   task automatic tick(string tag);
      advance();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic cfg_all(bit en, bit um, bit lvl, bit [1:0] code);
      irq_en = {N{en}};
      irq_unmask = {N{um}};
      lvl_mode = {N{lvl}};
      act_sel = {N{code}};
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 0;
      pin_level = '1; sts_clr = '0; wake_en = '0; pwr_state = 2'd0;
      cfg_all(1, 1, 0, 2'b01);
      for (int i = 0; i < N; i++) begin m_prev[i] = 0; m_sts[i] = 0; m_wake[i] = 0; end
      m_primed = 0;
      repeat (3) @(negedge clk);
      compare("R1");
      rst_n = 1;
      compare("R1");
      // R11: pin high at release, rising-edge mode: no edge on first sample
      tick("R11");
      tick("R11");

      // R2 rising edge
      pin_level = '0; tick("R2");
      pin_level = '1; tick("R2");
      tick("R12");
      // R7 clear with no event
      sts_clr = '1; tick("R7");
      sts_clr = '0; tick("R12");

      // R3 falling edge
      cfg_all(1, 1, 0, 2'b00);
      pin_level = '0; tick("R3");
      sts_clr = '1; tick("R7");
      sts_clr = '0;
      pin_level = '1; tick("R3");

      // R4 both edges
      cfg_all(1, 1, 0, 2'b10);
      pin_level = 4'b0101; tick("R4");
      sts_clr = '1; pin_level = 4'b0110; tick("R7");
      sts_clr = '1; pin_level = 4'b0110; tick("R7");
      sts_clr = '0;

      // R5 reserved codes
      cfg_all(1, 1, 0, 2'b11);
      pin_level = 4'b1001; tick("R5");
      pin_level = 4'b0110; tick("R5");
      cfg_all(1, 1, 1, 2'b11); tick("R5");
      cfg_all(1, 1, 1, 2'b10); tick("R5");

      // R6 level mode
      cfg_all(1, 1, 1, 2'b01);
      pin_level = 4'b0011; tick("R6");
      sts_clr = '1; tick("R6");
      tick("R6");
      cfg_all(1, 1, 1, 2'b00); tick("R6");
      pin_level = '1; tick("R6");
      sts_clr = '0;

      // R8 disable: toggle, then re-enable with steady level
      cfg_all(0, 1, 0, 2'b10);
      pin_level = '0; tick("R8");
      pin_level = '1; tick("R8");
      pin_level = '0; tick("R8");
      cfg_all(1, 1, 0, 2'b10); tick("R8");
      tick("R8");

      // R9 masking
      pin_level = '1; tick("R9");
      irq_unmask = 4'b1010; tick("R9");
      irq_en = 4'b0110; tick("R9");
      sts_clr = '1; tick("R9"); sts_clr = '0;

      // R10 wake
      cfg_all(1, 1, 0, 2'b10);
      wake_en = 12'b100_010_001_010;
      pwr_state = 2'd2; pin_level = '0; tick("R10");
      pwr_state = 2'd0; sts_clr = '1; tick("R10");
      sts_clr = '0; pin_level = '1; tick("R10");
      pwr_state = 2'd1; sts_clr = '1; pin_level = '0; tick("R10");
      sts_clr = '1; pwr_state = 2'd3; pin_level = '1; tick("R10");
      sts_clr = '0;

      // Random stretch
      for (int k = 0; k < 4000; k++) begin
         pin_level  = N'($urandom);
         irq_en     = N'($urandom) | N'($urandom);
         irq_unmask = N'($urandom);
         lvl_mode   = N'($urandom) & N'($urandom);
         act_sel    = (2*N)'($urandom);
         wake_en    = (N*WS)'($urandom);
         pwr_state  = 2'($urandom);
         sts_clr    = N'($urandom) & N'($urandom);
         tick("random");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule